// File: doc/BRIEF.md
# Way-Lockable Pairwise-Age Replacement Selector

This block picks the way to evict from one set of a 4-way set-associative cache. Each set keeps a 6-bit age code in which each bit records which member of one way pair was used less recently. The cache controller reports every hit or fill to the block as an access with a set index and a way number. When it needs a slot for a miss it raises a replacement request for the same set index. One cycle later the block returns the way to evict.

Two lock inputs can take way 2 and way 3 out of the replacement pool, either one alone or both together. A locked way still gets its age updated on access. It is never named as the victim while its lock is high. An access and a replacement request may arrive in the same cycle. In that case the victim is chosen from the age code as it stood before that access.

Top module: `locked_way_plru`

## Requirements
- R1: Reset makes every set's age code 000000, which orders the ways (most recent to least recent) 0, 1, 2, 3. While reset is low, victim_way_o and victim_valid_o are 0.
- R2: Bit 5 to bit 0 of the age code belong to the pairs (0,1), (0,2), (0,3), (1,2), (1,3), (2,3). A 1 means the lower way of the pair is the less recent. An access to way k makes k the most recent way of its set. The relative order of the other three ways does not change.
- R3: With both locks low, the victim is the least recently used of all four ways.
- R4: With only lock_w3_i high, the victim is the least recently used of ways 0, 1 and 2. For example, code 000000 selects way 2 and code 111111 selects way 0.
- R5: With only lock_w2_i high, the victim is the least recently used of ways 0, 1 and 3.
- R6: With both locks high, the victim is way 1 when bit 5 of the code is 0 (way 0 more recent than way 1). It is way 0 when bit 5 is 1.
- R7: When access_i and repl_req_i are high in the same cycle for a set, the victim comes from the age code before that cycle's update.
- R8: A replacement request registers its victim. victim_way_o shows it on the following cycle with victim_valid_o high for exactly that cycle. Without a request, victim_valid_o is 0 and victim_way_o keeps its last value.
- R9: Each set's age code changes only on accesses to that set index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_idx_i | input | IDX_W | Set index used by both the access and the replacement request |
| access_i | input | 1 | Hit or fill strobe for the way given by access_way_i |
| access_way_i | input | 2 | Way that was hit or filled |
| repl_req_i | input | 1 | Request for a victim in set set_idx_i |
| lock_w2_i | input | 1 | Keeps way 2 out of the victim pool |
| lock_w3_i | input | 1 | Keeps way 3 out of the victim pool |
| victim_way_o | output | 2 | Way chosen by the last request |
| victim_valid_o | output | 1 | High for the cycle after a request |

## Verification
The assertions assume two things about the inputs. set_idx_i is always below NUM_SETS. Every age code in the array was built from the reset code by access updates only, so each code is one of the 24 consistent orderings. The design's state-consistency assertion depends on that. The stimulus takes random set indices in range, with a bias toward a few sets so that orderings build up. It draws lock and strobe values freely, and it drives all state only through access_i. The bench keeps its own per-set usage timestamps and takes the expected victim as the unlocked way with the oldest timestamp.

// File: rtl/plru_pkg.sv
package plru_pkg;
  localparam int NUM_WAYS = 4;
  localparam int WAY_W    = $clog2(NUM_WAYS);
  localparam int PAIR_W   = NUM_WAYS * (NUM_WAYS - 1) / 2;

  typedef logic [PAIR_W-1:0] age_t;
  typedef logic [WAY_W-1:0]  way_t;

  // bit position of pair (lo,hi), lo<hi; first pair in enumeration is MSB
  function automatic int pair_bit(input int lo, input int hi);
    int p;
    p = 0;
    for (int a = 0; a < lo; a++) p += NUM_WAYS - 1 - a;
    p += hi - lo - 1;
    return PAIR_W - 1 - p;
  endfunction
endpackage

// File: rtl/plru_age_update.sv
module plru_age_update
  import plru_pkg::*;
(
  input  age_t age_i,
  input  way_t way_i,
  output age_t age_o
);
  for (genvar i = 0; i < NUM_WAYS; i++) begin : g_lo
    for (genvar j = i + 1; j < NUM_WAYS; j++) begin : g_hi
      localparam int B = pair_bit(i, j);
      always_comb begin
        if (way_i == WAY_W'(i))      age_o[B] = 1'b0;
        else if (way_i == WAY_W'(j)) age_o[B] = 1'b1;
        else                         age_o[B] = age_i[B];
      end
    end
  end
endmodule

// File: rtl/plru_victim_decode.sv
module plru_victim_decode
  import plru_pkg::*;
(
  input  age_t age_i,
  input  logic lock_w2_i,
  input  logic lock_w3_i,
  output way_t victim_o,
  output logic consistent_o
);
  logic [NUM_WAYS-1:0][NUM_WAYS-1:0] older;  // older[a][b]: a less recent than b
  logic [NUM_WAYS-1:0] locked;
  logic [NUM_WAYS-1:0] cand;
  logic [NUM_WAYS-1:0] rank_seen;

  assign locked = {lock_w3_i, lock_w2_i, {(NUM_WAYS-2){1'b0}}};

  always_comb begin
    for (int a = 0; a < NUM_WAYS; a++) begin
      for (int b = 0; b < NUM_WAYS; b++) begin
        if (a == b)     older[a][b] = 1'b0;
        else if (a < b) older[a][b] = age_i[pair_bit(a, b)];
        else            older[a][b] = ~age_i[pair_bit(b, a)];
      end
    end
  end

  // ordering is consistent iff the per-way older counts form a permutation
  always_comb begin
    rank_seen = '0;
    for (int a = 0; a < NUM_WAYS; a++) begin
      for (int r = 0; r < NUM_WAYS; r++) begin
        if ($countones(older[a]) == r) rank_seen[r] = 1'b1;
      end
    end
  end
  assign consistent_o = &rank_seen;

  always_comb begin
    for (int a = 0; a < NUM_WAYS; a++) begin
      cand[a] = ~locked[a];
      for (int b = 0; b < NUM_WAYS; b++) begin
        if (b != a && !locked[b] && !older[a][b]) cand[a] = 1'b0;
      end
    end
  end

  always_comb begin
    victim_o = '0;
    if (consistent_o) begin
      for (int a = NUM_WAYS - 1; a >= 0; a--) begin
        if (cand[a]) victim_o = WAY_W'(a);
      end
    end
  end
endmodule

// File: rtl/plru_state_array.sv
module plru_state_array
  import plru_pkg::*;
#(
  parameter int NUM_SETS = 64,
  localparam int IDX_W = $clog2(NUM_SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output age_t             rd_age_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  age_t             wr_age_i
);
  age_t mem_q [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       mem_q[s] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(s))         mem_q[s] <= wr_age_i;
    end
  end

  assign rd_age_o = mem_q[rd_idx_i];
endmodule

// File: rtl/locked_way_plru.sv
module locked_way_plru
  import plru_pkg::*;
#(
  parameter int NUM_SETS = 64,
  localparam int IDX_W = $clog2(NUM_SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic             access_i,
  input  logic [1:0]       access_way_i,
  input  logic             repl_req_i,
  input  logic             lock_w2_i,
  input  logic             lock_w3_i,
  output logic [1:0]       victim_way_o,
  output logic             victim_valid_o
);
  age_t cur_age;
  age_t nxt_age;
  way_t dec_victim;
  logic dec_consistent;

  plru_state_array #(.NUM_SETS(NUM_SETS)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_idx_i(set_idx_i),
    .rd_age_o(cur_age),
    .wr_en_i (access_i),
    .wr_idx_i(set_idx_i),
    .wr_age_i(nxt_age)
  );

  plru_age_update u_update (
    .age_i(cur_age),
    .way_i(access_way_i),
    .age_o(nxt_age)
  );

  // decode reads pre-update state, so a same-cycle access does not affect it
  plru_victim_decode u_decode (
    .age_i       (cur_age),
    .lock_w2_i   (lock_w2_i),
    .lock_w3_i   (lock_w3_i),
    .victim_o    (dec_victim),
    .consistent_o(dec_consistent)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      victim_way_o   <= '0;
      victim_valid_o <= 1'b0;
    end else begin
      victim_valid_o <= repl_req_i;
      if (repl_req_i) victim_way_o <= dec_victim;
    end
  end

  p_state_consistent_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_consistent);
  p_lock3_excluded_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    repl_req_i && lock_w3_i |=> victim_way_o != 2'd3);
  p_lock2_excluded_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    repl_req_i && lock_w2_i |=> victim_way_o != 2'd2);
  p_both_locked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    repl_req_i && lock_w2_i && lock_w3_i |=> victim_way_o[1] == 1'b0);
  p_valid_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    repl_req_i |=> victim_valid_o);
  p_valid_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !repl_req_i |=> !victim_valid_o);
  p_victim_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !repl_req_i |=> $stable(victim_way_o));
endmodule

// File: tb/locked_way_plru_test.sv
module locked_way_plru_test;
  localparam int NUM_SETS = 64;
  localparam int IDX_W = $clog2(NUM_SETS);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [IDX_W-1:0] set_idx_i = '0;
  logic access_i = 1'b0;
  logic [1:0] access_way_i = '0;
  logic repl_req_i = 1'b0;
  logic lock_w2_i = 1'b0;
  logic lock_w3_i = 1'b0;
  logic [1:0] victim_way_o;
  logic victim_valid_o;

  int n_checks = 0;
  int n_fail = 0;
  int stamp = 100;
  int last_use [NUM_SETS][4];
  bit done = 0;

  always #10 clk = ~clk;

  locked_way_plru #(.NUM_SETS(NUM_SETS)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .set_idx_i(set_idx_i), .access_i(access_i),
    .access_way_i(access_way_i), .repl_req_i(repl_req_i), .lock_w2_i(lock_w2_i),
    .lock_w3_i(lock_w3_i), .victim_way_o(victim_way_o), .victim_valid_o(victim_valid_o)
  );

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_victim(int s, bit l2, bit l3);
    int best = -1;
    for (int w = 0; w < 4; w++) begin
      if ((w == 2 && l2) || (w == 3 && l3)) continue;
      if (best < 0 || last_use[s][w] < last_use[s][best]) best = w;
    end
    return best;
  endfunction

  // called at a negedge; returns at the next negedge after checking outputs
  task automatic do_op(int s, bit acc, int way, bit req, bit l2, bit l3, string tag);
    int exp_v;
    int prev_v;
    prev_v = victim_way_o;
    set_idx_i = IDX_W'(s);
    access_i = acc;
    access_way_i = 2'(way);
    repl_req_i = req;
    lock_w2_i = l2;
    lock_w3_i = l3;
    exp_v = exp_victim(s, l2, l3);  // pre-update state (R7)
    if (acc) begin
      stamp++;
      last_use[s][way] = stamp;
    end
    @(negedge clk);
    check({tag, " R8 valid"}, victim_valid_o, req);
    if (req) check(tag, victim_way_o, exp_v);
    else     check("R8 hold", victim_way_o, prev_v);
    access_i = 1'b0;
    repl_req_i = 1'b0;
  endtask

  initial begin
    for (int s = 0; s < NUM_SETS; s++)
      for (int w = 0; w < 4; w++) last_use[s][w] = 3 - w;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 reset valid", victim_valid_o, 0);
    check("R1 reset way", victim_way_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: reset code 000000 across lock patterns
    do_op(0, 0, 0, 1, 0, 0, "R1 R3");
    do_op(0, 0, 0, 1, 0, 1, "R4 code000000");
    do_op(0, 0, 0, 1, 1, 0, "R5");
    do_op(0, 0, 0, 1, 1, 1, "R6 bit5=0");
    do_op(0, 0, 0, 0, 0, 0, "R8");
    // drive set 1 to code 111111
    for (int w = 0; w < 4; w++) do_op(1, 1, w, 0, 0, 0, "R2");
    do_op(1, 0, 0, 1, 0, 0, "R2 R3");
    do_op(1, 0, 0, 1, 0, 1, "R4 code111111");
    do_op(1, 0, 0, 1, 1, 1, "R6 bit5=1");
    do_op(0, 0, 0, 1, 0, 0, "R9 set0 untouched");
    // R7: access to LRU way in the same cycle as the request
    do_op(2, 1, 3, 1, 0, 0, "R7");
    do_op(2, 0, 0, 1, 0, 0, "R7 after");
    // R2: reaccess middle way keeps others' order
    do_op(3, 1, 1, 0, 0, 0, "R2");
    do_op(3, 0, 0, 1, 0, 0, "R2 R3");
    do_op(3, 0, 0, 1, 0, 1, "R2 R4");

    for (int n = 0; n < 4000; n++) begin
      int s;
      bit acc, req, l2, l3;
      s = ($urandom % 4 == 0) ? int'($urandom % NUM_SETS) : int'($urandom % 6);
      acc = ($urandom % 3) != 0;
      req = ($urandom % 2) == 1;
      l2 = ($urandom % 3) == 0;
      l3 = ($urandom % 3) == 0;
      do_op(s, acc, int'($urandom % 4), req, l2, l3,
            l2 && l3 ? "R6 rand" : l3 ? "R4 rand" : l2 ? "R5 rand" : "R3 R9 rand");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule